// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block sits beside the decode stage of an in-order pipeline and catches the one case that forwarding cannot cover. That case is a load whose result is needed by the instruction directly behind it. The load sits in the decode-to-execute register and the consumer sits in the fetch-to-decode register. The block compares the load's destination register number against both source register numbers of the consumer. When either matches, the block freezes the program counter and the fetch-to-decode register for one cycle. In the same cycle it turns the entry that goes into the decode-to-execute register into a bubble by clearing all of its control bits.

After that one-cycle pause, the load has moved one stage further. Its data can then reach the consumer through the normal write-back forwarding path, so no second pause is needed. The bubble clears the memory-read flag in the decode-to-execute register, and because of that the same load cannot trigger the interlock again.

A small harness surrounds the detector. It holds a program counter, a fetch-to-decode register, a control decoder and a decode-to-execute register, so the effect of the freeze can be seen at the ports. The instruction word is supplied from outside, addressed by the exported program counter.

Top module: `lu_stall_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the program counter is 0, the fetch-to-decode register holds the all-zero word, the decode-to-execute control bits are 0 and bubble is 0.
- R2: When the decode-to-execute entry has its memory-read bit set and its target register number (word bits 20:16) equals the consumer's first source field (bits 25:21) or its second source field (bits 20:16), bubble is 1 and both pc_write and ifid_write are 0 in that same cycle.
- R3: When the condition of R2 is false, pc_write and ifid_write are 1 and bubble is 0.
- R4: In the cycle after a bubble, the decode-to-execute control bits are all 0.
- R5: In the cycle after a bubble, the program counter and the fetch-to-decode word are unchanged.
- R6: A bubble is never raised in two consecutive cycles, so a single load stalls its consumer for exactly one cycle.
- R7: In the cycle after a non-bubble cycle, the program counter has advanced by 4, the fetch-to-decode register holds the word that was fetched, and the decode-to-execute control bits equal the decode of the previous fetch-to-decode word.
- R8: The control byte is {reg_dst, alu_op[1:0], alu_src, mem_read, mem_write, mem_to_reg, reg_write}, with reg_dst as bit 7. Opcode 0x23 (load) decodes to 0x1B. Opcode 0x2B (store) decodes to 0x14. Opcode 0 with a nonzero word decodes to 0xC1. Every other word, including all zeros, decodes to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_rdata_i | input | 32 | Instruction word fetched at pc_o |
| pc_o | output | 32 | Current program counter |
| ifid_instr_o | output | 32 | Word held in the fetch-to-decode register |
| idex_ctrl_o | output | 8 | Control byte held in the decode-to-execute register |
| pc_write_o | output | 1 | Program counter update enable |
| ifid_write_o | output | 1 | Fetch-to-decode register update enable |
| bubble_o | output | 1 | Clear the control bits entering the decode-to-execute register |

## Verification
The bench builds the block with its default widths: a 32-bit word, 5-bit register numbers and a 32-bit program counter. With these widths, short programs of real load, store and register-register encodings can be laid out in a small instruction array. These programs exercise a match on the first source field and a match on the second source field. They also cover a non-load writer followed by a reader, a load with one unrelated instruction between it and its reader, and two dependent loads in a row that each pause once.

// File: rtl/lu_pkg.sv
package lu_pkg;

    typedef struct packed {
        logic       reg_dst;
        logic [1:0] alu_op;
        logic       alu_src;
        logic       mem_read;
        logic       mem_write;
        logic       mem_to_reg;
        logic       reg_write;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
    parameter int IDX_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                          ex_mem_read_i,
    input  logic [IDX_W-1:0]              ex_rt_i,
    input  logic [NUM_SRC-1:0][IDX_W-1:0] dec_src_i,
    output logic                          pc_write_o,
    output logic                          ifid_write_o,
    output logic                          bubble_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[s] = (dec_src_i[s] == ex_rt_i);
    end

    always_comb begin
        bubble_o     = ex_mem_read_i && (|hit);
        pc_write_o   = !bubble_o;
        ifid_write_o = !bubble_o;
    end
endmodule

// File: rtl/lu_ctrl_decode.sv
module lu_ctrl_decode #(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr_i,
    output lu_pkg::ctrl_t      ctrl_o
);
    import lu_pkg::*;
    localparam int OPC_LSB = INSTR_W - 6;

    logic [5:0] opc;
    assign opc = instr_i[INSTR_W-1:OPC_LSB];

    always_comb begin
        ctrl_o = '0;
        if (instr_i != '0) begin
            unique case (opc)
                OPC_RTYPE: begin
                    ctrl_o.reg_dst   = 1'b1;
                    ctrl_o.alu_op    = 2'b10;
                    ctrl_o.reg_write = 1'b1;
                end
                OPC_LOAD: begin
                    ctrl_o.alu_src    = 1'b1;
                    ctrl_o.mem_read   = 1'b1;
                    ctrl_o.mem_to_reg = 1'b1;
                    ctrl_o.reg_write  = 1'b1;
                end
                OPC_STORE: begin
                    ctrl_o.alu_src   = 1'b1;
                    ctrl_o.mem_write = 1'b1;
                end
                default: ctrl_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/lu_front_regs.sv
module lu_front_regs #(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pc_write_i,
    input  logic               ifid_write_i,
    input  logic [INSTR_W-1:0] fetch_word_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [INSTR_W-1:0] ifid_instr_o
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [INSTR_W-1:0] instr;
    } front_t;

    front_t front_d, front_q;

    always_comb begin
        front_d = front_q;
        if (pc_write_i)   front_d.pc    = front_q.pc + PC_STEP;
        if (ifid_write_i) front_d.instr = fetch_word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) front_q <= '0;
        else        front_q <= front_d;
    end

    assign pc_o         = front_q.pc;
    assign ifid_instr_o = front_q.instr;
endmodule

// File: rtl/lu_idex_reg.sv
module lu_idex_reg #(
    parameter int IDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bubble_i,
    input  lu_pkg::ctrl_t      ctrl_i,
    input  logic [IDX_W-1:0]   rt_i,
    output lu_pkg::ctrl_t      ctrl_o,
    output logic [IDX_W-1:0]   rt_o
);
    typedef struct packed {
        lu_pkg::ctrl_t    ctrl;
        logic [IDX_W-1:0] rt;
    } idex_t;

    idex_t idex_d, idex_q;

    always_comb begin
        idex_d.rt   = rt_i;
        idex_d.ctrl = bubble_i ? '0 : ctrl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idex_q <= '0;
        else        idex_q <= idex_d;
    end

    assign ctrl_o = idex_q.ctrl;
    assign rt_o   = idex_q.rt;
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit #(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [INSTR_W-1:0]        imem_rdata_i,
    output logic [PC_W-1:0]           pc_o,
    output logic [INSTR_W-1:0]        ifid_instr_o,
    output logic [lu_pkg::CTRL_W-1:0] idex_ctrl_o,
    output logic                      pc_write_o,
    output logic                      ifid_write_o,
    output logic                      bubble_o
);
    import lu_pkg::*;
    localparam int NUM_SRC = 2;
    localparam int RS_LSB  = INSTR_W - 6 - IDX_W;
    localparam int RT_LSB  = RS_LSB - IDX_W;

    logic [INSTR_W-1:0]              ifid_instr;
    logic [NUM_SRC-1:0][IDX_W-1:0]   dec_src;
    ctrl_t                           dec_ctrl, ex_ctrl;
    logic [IDX_W-1:0]                ex_rt;
    logic                            pc_we, ifid_we, bubble;

    assign dec_src[0] = ifid_instr[RS_LSB +: IDX_W];
    assign dec_src[1] = ifid_instr[RT_LSB +: IDX_W];

    lu_front_regs #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_write_i   (pc_we),
        .ifid_write_i (ifid_we),
        .fetch_word_i (imem_rdata_i),
        .pc_o         (pc_o),
        .ifid_instr_o (ifid_instr)
    );

    lu_ctrl_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr_i (ifid_instr),
        .ctrl_o  (dec_ctrl)
    );

    lu_hazard_detect #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_haz (
        .ex_mem_read_i (ex_ctrl.mem_read),
        .ex_rt_i       (ex_rt),
        .dec_src_i     (dec_src),
        .pc_write_o    (pc_we),
        .ifid_write_o  (ifid_we),
        .bubble_o      (bubble)
    );

    lu_idex_reg #(.IDX_W(IDX_W)) u_idex (
        .clk      (clk),
        .rst_n    (rst_n),
        .bubble_i (bubble),
        .ctrl_i   (dec_ctrl),
        .rt_i     (dec_src[1]),
        .ctrl_o   (ex_ctrl),
        .rt_o     (ex_rt)
    );

    assign ifid_instr_o = ifid_instr;
    assign idex_ctrl_o  = ex_ctrl;
    assign pc_write_o   = pc_we;
    assign ifid_write_o = ifid_we;
    assign bubble_o     = bubble;

    a_r4_bubble_clears_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ex_ctrl == '0));

    a_r5_front_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (pc_o == $past(pc_o)) && (ifid_instr == $past(ifid_instr)));

    a_r6_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);

    a_r7_pc_advances: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |=> (pc_o == $past(pc_o) + PC_W'(4)));

    a_r7_ctrl_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |=> (ex_ctrl == $past(dec_ctrl)));

    a_r2_load_match_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ctrl.mem_read && (ex_rt == ifid_instr[RS_LSB +: IDX_W])) |-> !pc_we && !ifid_we);
endmodule

// File: tb/test_lu_stall_unit.sv
module test_lu_stall_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_rdata;
    logic [31:0] pc, ifid_instr;
    logic [7:0]  idex_ctrl;
    logic        pc_write, ifid_write, bubble;

    logic [31:0] imem [16];

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed {
        logic [31:0] pc;
        logic        bub;
        logic [31:0] ifid;
        logic [7:0]  ctrl;
        logic [7:0]  tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_rdata = imem[pc[5:2]];

    lu_stall_unit i_lu_stall_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .imem_rdata_i (imem_rdata),
        .pc_o         (pc),
        .ifid_instr_o (ifid_instr),
        .idex_ctrl_o  (idex_ctrl),
        .pc_write_o   (pc_write),
        .ifid_write_o (ifid_write),
        .bubble_o     (bubble)
    );

    function automatic logic [31:0] op_lw(input logic [4:0] rs, input logic [4:0] rt);
        return {6'h23, rs, rt, 16'h0004};
    endfunction
    function automatic logic [31:0] op_sw(input logic [4:0] rs, input logic [4:0] rt);
        return {6'h2B, rs, rt, 16'h0008};
    endfunction
    function automatic logic [31:0] op_add(input logic [4:0] rs, input logic [4:0] rt,
                                           input logic [4:0] rd);
        return {6'h00, rs, rt, rd, 5'h00, 6'h20};
    endfunction

    // R8 control byte table
    function automatic logic [7:0] ctrl_of(input logic [31:0] w);
        if (w == 32'h0)               return 8'h00;
        else if (w[31:26] == 6'h00)   return 8'hC1;
        else if (w[31:26] == 6'h23)   return 8'h1B;
        else if (w[31:26] == 6'h2B)   return 8'h14;
        else                          return 8'h00;
    endfunction

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (pc !== e.pc || bubble !== e.bub || pc_write !== !e.bub ||
                ifid_write !== !e.bub || ifid_instr !== e.ifid || idex_ctrl !== e.ctrl) begin
                n_fail++;
                $display("FAIL R%0s case %0d: pc=%h bub=%b pcw=%b ifw=%b ifid=%h ctrl=%h | exp pc=%h bub=%b ifid=%h ctrl=%h",
                         e.tag == 8'd1 ? "1" : e.tag == 8'd2 ? "2/R5/R4" : "3/R7/R6", n_tests,
                         pc, bubble, pc_write, ifid_write, ifid_instr, idex_ctrl,
                         e.pc, e.bub, e.ifid, e.ctrl);
            end
        end
    end

    task automatic push(input int p, input bit b, input logic [31:0] w,
                        input logic [7:0] c, input logic [7:0] tag);
        exp_t e;
        e.pc = 32'(p); e.bub = b; e.ifid = w; e.ctrl = c; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic load_and_reset(input logic [31:0] w0, input logic [31:0] w1,
                                  input logic [31:0] w2);
        for (int i = 0; i < 16; i++) imem[i] = 32'h0;
        imem[0] = w0; imem[1] = w1; imem[2] = w2;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (pc !== 0 || ifid_instr !== 0 || idex_ctrl !== 0 || bubble !== 0) begin
            n_fail++;
            $display("FAIL R1 in reset: pc=%h ifid=%h ctrl=%h bub=%b exp 0", pc, ifid_instr, idex_ctrl, bubble);
        end
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic drain;
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] a, b, c;
        for (int i = 0; i < 16; i++) imem[i] = 32'h0;

        // Case A: load r2 then add reading r2 in its first source field (R2, R4, R5, R6)
        a = op_lw(5'd1, 5'd2); b = op_add(5'd2, 5'd4, 5'd3);
        load_and_reset(a, b, 32'h0);
        push(0, 0, 32'h0, 8'h00, 1);               step;  // R1
        push(4, 0, a, 8'h00, 3);                   step;  // R7
        push(8, 1, b, ctrl_of(a), 2);              step;  // R2 stall
        push(8, 0, b, 8'h00, 2);                   step;  // R4 R5 R6
        push(12, 0, 32'h0, ctrl_of(b), 3);         step;  // R7 R8
        push(16, 0, 32'h0, 8'h00, 3);
        drain;

        // Case B: load r2 then unrelated add: no stall (R3)
        a = op_lw(5'd1, 5'd2); b = op_add(5'd5, 5'd6, 5'd3);
        load_and_reset(a, b, 32'h0);
        push(0, 0, 32'h0, 8'h00, 1);               step;
        push(4, 0, a, 8'h00, 3);                   step;
        push(8, 0, b, ctrl_of(a), 3);              step;  // R3
        push(12, 0, 32'h0, ctrl_of(b), 3);
        drain;

        // Case C: load r2 then store whose second source field is r2 (R2)
        a = op_lw(5'd1, 5'd2); b = op_sw(5'd7, 5'd2);
        load_and_reset(a, b, 32'h0);
        push(0, 0, 32'h0, 8'h00, 1);               step;
        push(4, 0, a, 8'h00, 3);                   step;
        push(8, 1, b, ctrl_of(a), 2);              step;  // R2 via bits 20:16
        push(8, 0, b, 8'h00, 2);                   step;  // R4 R5
        push(12, 0, 32'h0, ctrl_of(b), 3);                // R8 store 0x14
        drain;

        // Case D: non-load writer then reader: no stall (R3)
        a = op_add(5'd1, 5'd1, 5'd2); b = op_add(5'd2, 5'd2, 5'd3);
        load_and_reset(a, b, 32'h0);
        push(0, 0, 32'h0, 8'h00, 1);               step;
        push(4, 0, a, 8'h00, 3);                   step;
        push(8, 0, b, ctrl_of(a), 3);              step;  // R3
        push(12, 0, 32'h0, ctrl_of(b), 3);
        drain;

        // Case E: load, one gap, then reader: no stall (R3)
        a = op_lw(5'd1, 5'd2); c = op_add(5'd2, 5'd0, 5'd3);
        load_and_reset(a, 32'h0, c);
        push(0, 0, 32'h0, 8'h00, 1);               step;
        push(4, 0, a, 8'h00, 3);                   step;
        push(8, 0, 32'h0, ctrl_of(a), 3);          step;
        push(12, 0, c, 8'h00, 3);                  step;  // R3
        push(16, 0, 32'h0, ctrl_of(c), 3);
        drain;

        // Case F: two chained loads then reader: two separate single stalls (R6)
        a = op_lw(5'd1, 5'd2); b = op_lw(5'd2, 5'd4); c = op_add(5'd4, 5'd4, 5'd5);
        load_and_reset(a, b, c);
        push(0, 0, 32'h0, 8'h00, 1);               step;
        push(4, 0, a, 8'h00, 3);                   step;
        push(8, 1, b, ctrl_of(a), 2);              step;  // R2
        push(8, 0, b, 8'h00, 2);                   step;  // R6
        push(12, 1, c, ctrl_of(b), 2);             step;  // R2 again
        push(12, 0, c, 8'h00, 2);                  step;  // R6
        push(16, 0, 32'h0, ctrl_of(c), 3);
        drain;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired (R1..): actual hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule